// File: doc/BRIEF.md
# Memory Rail State Sequencer

This block is the digital state controller for a dual-rail memory power supply. It has three operating states: full-on (S0), standby (S3) and off (S5). It picks one of them from four supply flags: standby supply good, main supply good, sleep request and maximum duty reached. From that state it drives the enables for the main switching stage, the standby switcher and the termination regulator. It also issues a soft-start restart pulse each time the supply leaves the off state.

A sleep request alone does not take the block out of full-on. S0 falls to S3 only when the main supply drops or the duty limit is reached while the request is up. The termination regulator is enabled only after the main rail reports that it is in regulation. The active-low power-good output is released only in S0 with both rails in regulation, and only after a programmable hold delay counted in clock cycles.

All flag inputs are treated as asynchronous. They pass through two-flop synchronizers before any decision uses them.

Top module: `mem_rail_seq`

## Requirements
- R1: Whenever the synchronized standby-supply-good flag is low, the next state is S5, whatever the other inputs are.
- R2: From S5, with the sleep request low, the block enters S0 if main-supply-good is high and stays in S5 otherwise. With the sleep request high it stays in S5.
- R3: In S0 with the sleep request high, the block stays in S0 while main-supply-good is high and maximum-duty is low. It moves to S3 if maximum-duty is high or main-supply-good is low.
- R4: In S0 with the sleep request low, losing main-supply-good moves the block to S5. Maximum-duty has no effect on the state.
- R5: In S3, the block stays in S3 while the sleep request is high. When the request drops, it goes to S0 if main-supply-good is high and to S5 otherwise.
- R6: The mode is encoded on two enables. In S0, main_en_o=1 and stby_sw_en_o=0. In S3, main_en_o=0 and stby_sw_en_o=1. In S5, both are 0. The two are never high together.
- R7: term_en_o is high only in S0 while the synchronized main-rail in-regulation flag is high. It rises two clock edges after that flag rises, and it is low in S3 and S5.
- R8: ss_restart_o is a one-cycle pulse that coincides with the first cycle of S0 after S5. It does not pulse on a return from S3 to S0.
- R9: pg_pull_o (1 = pull low, 0 = released) is 0 only in S0 with both synchronized in-regulation flags high. It falls HOLD_CYC edges after that condition first holds, and it is 1 in S3 and S5.
- R10: If the power-good condition drops for even one cycle, the hold count restarts from zero and pg_pull_o returns to 1 at once.
- R11: Every flag input passes through a two-flop synchronizer, so a state change shows on the enables at the third rising edge after the input changes. During reset the state is S5, pg_pull_o is 1 and all enables and the pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_ok_i | input | 1 | Standby supply good (asynchronous) |
| main_ok_i | input | 1 | Main supply good (asynchronous) |
| sleep_req_i | input | 1 | Standby request (asynchronous) |
| duty_max_i | input | 1 | Maximum duty reached (asynchronous) |
| main_inreg_i | input | 1 | Main rail in regulation (asynchronous) |
| term_inreg_i | input | 1 | Termination rail in regulation (asynchronous) |
| main_en_o | output | 1 | Main switching stage enable, high in S0 only |
| stby_sw_en_o | output | 1 | Standby switcher enable, high in S3 only |
| term_en_o | output | 1 | Termination regulator enable |
| ss_restart_o | output | 1 | One-cycle soft-start restart pulse |
| pg_pull_o | output | 1 | Power-good pull-down; 0 means released |

## Verification
A change on a state input shows on the enables at the third rising edge after the change: two edges for the synchronizer and one for the state register. The sweep checks that the mode is still the old one after two edges and the new one after three, sampling on the falling edge. The termination enable is due two edges after the main in-regulation flag rises. Power-good is released 2+HOLD_CYC edges after the second in-regulation flag rises. After a one-cycle dropout that flag is not released until 3+HOLD_CYC edges, and the bench samples one edge on each side of every one of these deadlines.

// File: rtl/mem_rail_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state type for the memory rail sequencer.
// Assumes: three operating states, encoded in two bits.
package mem_rail_seq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // S5: all rails off
        ST_ON   = 2'd1,   // S0: full operation
        ST_STBY = 2'd2    // S3: standby switcher only
    } rail_state_e;

    localparam int NUM_FLAGS = 6;
    // Bit positions of the flags in the synchronizer bus
    localparam int FL_AUX   = 0;
    localparam int FL_MAIN  = 1;
    localparam int FL_SLEEP = 2;
    localparam int FL_DUTY  = 3;
    localparam int FL_MREG  = 4;
    localparam int FL_TREG  = 5;
endpackage

// File: rtl/mem_rail_flag_sync.sv
`timescale 1ns/1ps
// Module: multi-bit flag synchronizer.
// Each bit passes independently through STAGES flops; bits are
// assumed to be slow level flags, so no cross-bit coherency is given.
module mem_rail_flag_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous flags
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Move the flags one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mem_rail_state_fsm.sv
`timescale 1ns/1ps
// Module: operating state decoder.
// Picks S0/S3/S5 from synchronized supply flags and emits a one-cycle
// restart pulse on the first S0 cycle after S5.
// Assumes: all inputs are already synchronous to clk.
module mem_rail_state_fsm
    import mem_rail_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        aux_ok,
    input  logic        main_ok,
    input  logic        sleep_req,
    input  logic        duty_max,
    output rail_state_e state_o,
    output logic        restart_o
);
    rail_state_e state_q, state_d;
    logic        restart_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (!aux_ok) begin
            state_d = ST_OFF;
        end else if (!sleep_req) begin
            state_d = main_ok ? ST_ON : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_ON:   state_d = (main_ok && !duty_max) ? ST_ON : ST_STBY;
                ST_STBY: state_d = ST_STBY;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register and restart pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= (state_q == ST_OFF) && (state_d == ST_ON);
        end
    end

    assign state_o   = state_q;
    assign restart_o = restart_q;
endmodule

// File: rtl/mem_rail_pg_hold.sv
`timescale 1ns/1ps
// Module: power-good hold timer.
// Releases once the qualifying condition has held for HOLD_CYC edges;
// any dropout clears the count and withdraws the release at once.
// Assumes: HOLD_CYC >= 1.
module mem_rail_pg_hold #(
    parameter int HOLD_CYC = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic release_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    // Count qualified cycles, saturating at the hold limit
    always_ff @(posedge clk) begin
        if (!rst_n || !qual_i) cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign release_o = qual_i && (cnt_q == CNT_TOP);
endmodule

// File: rtl/mem_rail_seq.sv
`timescale 1ns/1ps
// Module: memory rail state sequencer (top).
// Synchronizes the supply flags, decodes the state, gates the
// termination enable on main-rail regulation and times power-good.
// Assumes: flags are level signals that are stable for several cycles.
module mem_rail_seq
    import mem_rail_seq_pkg::*;
#(
    parameter int HOLD_CYC    = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_ok_i,
    input  logic main_ok_i,
    input  logic sleep_req_i,
    input  logic duty_max_i,
    input  logic main_inreg_i,
    input  logic term_inreg_i,
    output logic main_en_o,
    output logic stby_sw_en_o,
    output logic term_en_o,
    output logic ss_restart_o,
    output logic pg_pull_o
);
    logic [NUM_FLAGS-1:0] flag_raw, flag_s;
    logic        aux_ok_s, main_ok_s, sleep_s, duty_s;
    logic        main_inreg_s, term_inreg_s;
    rail_state_e state;
    logic        pg_qual, pg_release;

    // Collect the raw flags into one bus
    always_comb begin
        flag_raw           = '0;
        flag_raw[FL_AUX]   = aux_ok_i;
        flag_raw[FL_MAIN]  = main_ok_i;
        flag_raw[FL_SLEEP] = sleep_req_i;
        flag_raw[FL_DUTY]  = duty_max_i;
        flag_raw[FL_MREG]  = main_inreg_i;
        flag_raw[FL_TREG]  = term_inreg_i;
    end

    mem_rail_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flag_raw),
        .sync_o  (flag_s)
    );

    assign aux_ok_s     = flag_s[FL_AUX];
    assign main_ok_s    = flag_s[FL_MAIN];
    assign sleep_s      = flag_s[FL_SLEEP];
    assign duty_s       = flag_s[FL_DUTY];
    assign main_inreg_s = flag_s[FL_MREG];
    assign term_inreg_s = flag_s[FL_TREG];

    mem_rail_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .aux_ok    (aux_ok_s),
        .main_ok   (main_ok_s),
        .sleep_req (sleep_s),
        .duty_max  (duty_s),
        .state_o   (state),
        .restart_o (ss_restart_o)
    );

    assign pg_qual = (state == ST_ON) && main_inreg_s && term_inreg_s;

    mem_rail_pg_hold #(.HOLD_CYC(HOLD_CYC)) u_pg (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual_i    (pg_qual),
        .release_o (pg_release)
    );

    // Output decode from the state
    assign main_en_o    = (state == ST_ON);
    assign stby_sw_en_o = (state == ST_STBY);
    assign term_en_o    = (state == ST_ON) && main_inreg_s;
    assign pg_pull_o    = !pg_release;
endmodule

// File: rtl/mem_rail_seq_chk.sv
`timescale 1ns/1ps
// Module: property checker for the rail sequencer, bound to the top.
// Assumes: observes ports plus the synchronized regulation flags.
module mem_rail_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic aux_ok_s,
    input logic main_inreg_s,
    input logic term_inreg_s,
    input logic main_en_o,
    input logic stby_sw_en_o,
    input logic term_en_o,
    input logic ss_restart_o,
    input logic pg_pull_o
);
    p_aux_loss_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_ok_s |=> (!main_en_o && !stby_sw_en_o));

    p_stby_from_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stby_sw_en_o) |-> $past(main_en_o));

    p_mode_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en_o && stby_sw_en_o));

    p_term_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_en_o |-> (main_en_o && main_inreg_s));

    p_restart_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart_o |-> (main_en_o && $past(!main_en_o && !stby_sw_en_o)));

    p_restart_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart_o |=> !ss_restart_o);

    p_pg_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_o |-> (main_en_o && main_inreg_s && term_inreg_s));

    p_pg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pull_o) |-> $past(main_en_o && main_inreg_s && term_inreg_s));
endmodule

bind mem_rail_seq mem_rail_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .aux_ok_s     (aux_ok_s),
    .main_inreg_s (main_inreg_s),
    .term_inreg_s (term_inreg_s),
    .main_en_o    (main_en_o),
    .stby_sw_en_o (stby_sw_en_o),
    .term_en_o    (term_en_o),
    .ss_restart_o (ss_restart_o),
    .pg_pull_o    (pg_pull_o)
);

// File: tb/mem_rail_seq_test.sv
`timescale 1ns/1ps
// Bench: sweeps every flag combination from each state, then directed
// checks of termination gating, restart pulse and power-good hold.
module mem_rail_seq_test;
    localparam int HOLD = 6;
    localparam int M_OFF = 0, M_ON = 1, M_STBY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aux = 0, mok = 0, req = 0, duty = 0, mreg = 0, treg = 0;
    logic main_en, stby_en, term_en, ss, pg_pull;
    int   n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    mem_rail_seq #(.HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n),
        .aux_ok_i(aux), .main_ok_i(mok), .sleep_req_i(req),
        .duty_max_i(duty), .main_inreg_i(mreg), .term_inreg_i(treg),
        .main_en_o(main_en), .stby_sw_en_o(stby_en), .term_en_o(term_en),
        .ss_restart_o(ss), .pg_pull_o(pg_pull)
    );

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog R11 act=%0d exp=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int mode();
        if (main_en && stby_en) return 3;
        if (main_en) return M_ON;
        if (stby_en) return M_STBY;
        return M_OFF;
    endfunction

    // Expected next state from the requirements
    function automatic int ref_next(int p, logic a, logic m, logic r, logic d);
        if (!a) return M_OFF;
        if (!r) return m ? M_ON : M_OFF;
        if (p == M_ON) return (m && !d) ? M_ON : M_STBY;
        return p;
    endfunction

    function automatic string tag_of(int p, logic a, logic r);
        if (!a) return "R1";
        if (p == M_OFF) return "R2";
        if (p == M_ON) return r ? "R3" : "R4";
        return "R5";
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_off();
        aux = 0; tick(3);
    endtask
    task automatic go_on();
        aux = 1; mok = 1; req = 0; duty = 0; tick(3);
    endtask
    task automatic go_stby();
        go_on(); req = 1; mok = 0; tick(3);
    endtask

    initial begin
        // R11: reset state
        tick(3);
        chk("R11 reset mode", mode(), M_OFF);
        chk("R11 reset pg", pg_pull, 1);
        chk("R11 reset term", term_en, 0);
        chk("R11 reset pulse", ss, 0);
        rst_n = 1;
        tick(1);

        // Sweep all flag combinations from each state (R1..R6, R11)
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 16; c++) begin
                int exp_m;
                if (s == M_OFF) go_off();
                else if (s == M_ON) go_on();
                else go_stby();
                chk("R6 start mode", mode(), s);
                aux = c[0]; mok = c[1]; req = c[2]; duty = c[3];
                exp_m = ref_next(s, c[0], c[1], c[2], c[3]);
                tick(2);
                chk("R11 latency hold", mode(), s);
                tick(1);
                chk(tag_of(s, c[0], c[2]), mode(), exp_m);
            end
        end

        // R7: termination enable gating
        mreg = 0; treg = 0;
        go_off(); go_on();
        chk("R7 term off before reg", term_en, 0);
        mreg = 1;
        tick(1);
        chk("R7 term one edge", term_en, 0);
        tick(1);
        chk("R7 term two edges", term_en, 1);
        req = 1; mok = 0; tick(3);
        chk("R7 term in S3", term_en, 0);
        chk("R6 mode S3", mode(), M_STBY);

        // R8: restart pulse only when leaving S5
        go_off();
        aux = 1; mok = 1; req = 0; duty = 0;
        tick(2);
        chk("R8 no early pulse", ss, 0);
        tick(1);
        chk("R8 pulse", ss, 1);
        chk("R8 pulse in S0", mode(), M_ON);
        tick(1);
        chk("R8 pulse one cycle", ss, 0);
        req = 1; mok = 0; tick(3);
        req = 0; mok = 1; tick(3);
        chk("R8 S3 to S0 mode", mode(), M_ON);
        chk("R8 no pulse from S3", ss, 0);

        // R9: power-good hold delay
        mreg = 1; treg = 0;
        go_off(); go_on(); tick(3);
        chk("R9 pg held without term reg", pg_pull, 1);
        treg = 1;
        tick(1 + HOLD);
        chk("R9 pg before hold", pg_pull, 1);
        tick(1);
        chk("R9 pg released", pg_pull, 0);

        // R10: one-cycle dropout restarts the hold
        treg = 0;
        tick(1);
        treg = 1;
        tick(1);
        chk("R10 pg pulled on dropout", pg_pull, 1);
        tick(HOLD);
        chk("R10 hold restarted", pg_pull, 1);
        tick(1);
        chk("R10 pg released again", pg_pull, 0);

        // R9: pulled in S3 and S5
        req = 1; mok = 0; tick(3);
        chk("R9 pg in S3", pg_pull, 1);
        go_off();
        chk("R9 pg in S5", pg_pull, 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule